// File: doc/BRIEF.md
# Oversampled Video Pixel Capture Unit

This unit digitises a two-bit video stream from an older computer. It samples the stream at four times the pixel rate, which is a 48 MHz sampling clock for a 12 MHz pixel clock. For each video bit it keeps a short window of recent samples. Once every four sampling clocks it turns the window into one pixel bit, then writes the two-bit pixel into a frame buffer through an address, a data word and a write strobe. The display controller and the frame-buffer memory are outside the unit.

The sampling phase is set again only at each horizontal sync. No clock recovery runs within a line. A six-bit control word sets two things. Its two top bits choose whether each video bit is read from samples taken on the rising or on the falling clock edge. Its four low bits give the pixel value for each count of ones in the window. This replaces a fixed majority rule. The preferred control word is `111100`: rising edges for both bits, and a pixel is on only when three or four of its samples are 1.

A line controller has four states.
- `ST_WAIT_LINE` is entered at reset or on a vertical sync edge. A horizontal sync edge moves it to `ST_CAPTURE` at row 0.
- `ST_CAPTURE` issues writes. After the last pixel of a line it moves to `ST_LINE_END`.
- In `ST_CAPTURE` or `ST_LINE_END`, a horizontal sync edge steps to the next row and returns to `ST_CAPTURE`. If the current row is the last row, it moves to `ST_FRAME_END` instead.
- `ST_FRAME_END` ignores horizontal sync.
- A vertical sync edge moves any state back to `ST_WAIT_LINE`.

Top module: `vcap_pixel_capture`

## Requirements
- R1: While reset is low, and after it is released until the first capture write, `fb_we`, `fb_addr` and `fb_data` are all 0.
- R2: In `ST_CAPTURE`, `fb_we` pulses for one clock exactly once every 4 clocks. The pulses of one line are exactly 4 clocks apart.
- R3: A pixel bit whose four window samples are all 0 is written as 0, whatever the control word is.
- R4: For a pixel bit with k ones in its window (k = 1..4), the written bit equals `ctrl_word[k-1]`. This holds for every arrangement of those ones. `fb_data[1]` comes from `vid_hi` and `fb_data[0]` from `vid_lo`.
- R5: `ctrl_word[5]` selects the sample edge for `vid_hi` and `ctrl_word[4]` selects it for `vid_lo`. A value of 1 selects rising-edge samples and 0 selects falling-edge samples. A falling-edge sample is taken half a clock after the rising-edge sample of the same input value.
- R6: Each write goes to the address row × PIX + column. The column starts at 0 on every horizontal sync edge and rises by 1 per write. Each horizontal sync edge after the first one of a frame steps the row by 1.
- R7: At most PIX writes occur between two horizontal sync edges. Later pixel slots are ignored, so `fb_addr` stays below PIX × ROWS.
- R8: A vertical sync edge sets the row back to 0 and stops writes. The next horizontal sync edge starts a line that writes from address 0.
- R9: A horizontal sync edge that arrives while the last row is current leads to `ST_FRAME_END`. No write then occurs until a vertical sync edge.
- R10: Both sync inputs pass through a two-flop synchronizer, and a rising edge is detected after it. The first write of a line is visible after the 7th rising clock edge that follows the change of `hsync_in`. A write due in the same clock as a detected sync edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| vid_hi | input | 1 | Upper video bit |
| vid_lo | input | 1 | Lower video bit |
| ctrl_word | input | OS+2 | [5] edge for upper bit, [4] edge for lower bit, [3:0] value per count of ones |
| fb_addr | output | clog2(PIX×ROWS) | Frame-buffer write address |
| fb_data | output | 2 | Pixel word {upper, lower} |
| fb_we | output | 1 | Frame-buffer write strobe |

## Verification
The bench builds the unit with PIX = 6 pixels per line and ROWS = 3 rows, and keeps 4 samples per pixel. Short lines let the bench reach the column limit (R7) within a few dozen clocks. Three rows make the frame-full state (R9) and the restart after vertical sync (R8) reachable in a handful of lines. A line width that is not a power of two exercises the row-base arithmetic in the address.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    // Line controller states
    typedef enum logic [1:0] {
        ST_WAIT_LINE = 2'd0,
        ST_CAPTURE   = 2'd1,
        ST_LINE_END  = 2'd2,
        ST_FRAME_END = 2'd3
    } cap_state_e;

    // Index of the edge-select bits inside the control word
    function automatic int hi_edge_bit(input int os);
        return os + 1;
    endfunction

    function automatic int lo_edge_bit(input int os);
        return os;
    endfunction

endpackage

// File: rtl/vcap_sync.sv
module vcap_sync #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] async_in,
    output logic [NUM-1:0] rise
);

    // Per input: two synchronizing flops, then one history flop for edge detection
    for (genvar g = 0; g < NUM; g++) begin : g_sync
        logic [2:0] stg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else begin
                stg_q <= {stg_q[1:0], async_in[g]};
            end
        end

        assign rise[g] = stg_q[1] & ~stg_q[2];
    end

endmodule

// File: rtl/vcap_sample_chain.sv
module vcap_sample_chain #(
    parameter int OS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic          sel_rise,
    output logic [OS-1:0] window
);

    // Bit 0 of each chain holds the newest sample
    logic [OS-1:0] rise_q;
    logic [OS-1:0] fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= {rise_q[OS-2:0], din};
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= {fall_q[OS-2:0], din};
        end
    end

    assign window = sel_rise ? rise_q : fall_q;

endmodule

// File: rtl/vcap_voter.sv
module vcap_voter #(
    parameter int OS = 4
) (
    input  logic [OS-1:0] win,
    input  logic [OS-1:0] level_sel,
    output logic          bit_out
);

    localparam int CW = $clog2(OS + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < OS; i++) begin
            ones = ones + {{(CW-1){1'b0}}, win[i]};
        end
    end

    // A count of zero always gives 0; a count of k gives level_sel[k-1]
    always_comb begin
        bit_out = 1'b0;
        for (int k = 1; k <= OS; k++) begin
            if (ones == CW'(k)) begin
                bit_out = level_sel[k-1];
            end
        end
    end

endmodule

// File: rtl/vcap_line_fsm.sv
module vcap_line_fsm
    import vcap_pkg::*;
#(
    parameter int OS     = 4,
    parameter int PIX    = 512,
    parameter int ROWS   = 256,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_rise,
    input  logic              vs_rise,
    input  logic [1:0]        pix_bits,
    output cap_state_e        state_o,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [1:0]        fb_data
);

    localparam int PH_W  = $clog2(OS);
    localparam int COL_W = $clog2(PIX);
    localparam int ROW_W = $clog2(ROWS);

    cap_state_e        state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [ADDR_W-1:0] base_q;

    logic last_phase, last_col, last_row;

    assign last_phase = (phase_q == PH_W'(OS - 1));
    assign last_col   = (col_q == COL_W'(PIX - 1));
    assign last_row   = (row_q == ROW_W'(ROWS - 1));
    assign state_o    = state_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (vs_rise) begin
            state_d = ST_WAIT_LINE;
        end else if (hs_rise) begin
            unique case (state_q)
                ST_WAIT_LINE: state_d = ST_CAPTURE;
                ST_CAPTURE,
                ST_LINE_END:  state_d = last_row ? ST_FRAME_END : ST_CAPTURE;
                ST_FRAME_END: state_d = ST_FRAME_END;
            endcase
        end else if (state_q == ST_CAPTURE && last_phase && last_col) begin
            state_d = ST_LINE_END;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_LINE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counters and frame-buffer outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            col_q   <= '0;
            row_q   <= '0;
            base_q  <= '0;
            fb_we   <= 1'b0;
            fb_addr <= '0;
            fb_data <= '0;
        end else begin
            fb_we <= 1'b0;
            if (vs_rise) begin
                phase_q <= '0;
                col_q   <= '0;
                row_q   <= '0;
                base_q  <= '0;
            end else if (hs_rise) begin
                if (state_q != ST_FRAME_END) begin
                    phase_q <= '0;
                    col_q   <= '0;
                    if (state_q != ST_WAIT_LINE && !last_row) begin
                        row_q  <= row_q + ROW_W'(1);
                        base_q <= base_q + ADDR_W'(PIX);
                    end
                end
            end else if (state_q == ST_CAPTURE) begin
                if (last_phase) begin
                    phase_q <= '0;
                    if (!last_col) begin
                        col_q <= col_q + COL_W'(1);
                    end
                    fb_we   <= 1'b1;
                    fb_addr <= base_q + ADDR_W'(col_q);
                    fb_data <= pix_bits;
                end else begin
                    phase_q <= phase_q + PH_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vcap_pixel_capture.sv
module vcap_pixel_capture
    import vcap_pkg::*;
#(
    parameter  int OS     = 4,
    parameter  int PIX    = 512,
    parameter  int ROWS   = 256,
    localparam int ADDR_W = $clog2(PIX * ROWS),
    localparam int CTRL_W = OS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              vid_hi,
    input  logic              vid_lo,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [1:0]        fb_data,
    output logic              fb_we
);

    logic [1:0]    sync_rise;
    logic          hs_rise, vs_rise;
    logic [OS-1:0] hi_window, lo_window;
    logic          hi_bit, lo_bit;
    cap_state_e    fsm_state;

    vcap_sync #(.NUM(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({vsync_in, hsync_in}),
        .rise     (sync_rise)
    );

    assign hs_rise = sync_rise[0];
    assign vs_rise = sync_rise[1];

    vcap_sample_chain #(.OS(OS)) u_chain_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (vid_hi),
        .sel_rise (ctrl_word[hi_edge_bit(OS)]),
        .window   (hi_window)
    );

    vcap_sample_chain #(.OS(OS)) u_chain_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (vid_lo),
        .sel_rise (ctrl_word[lo_edge_bit(OS)]),
        .window   (lo_window)
    );

    vcap_voter #(.OS(OS)) u_vote_hi (
        .win       (hi_window),
        .level_sel (ctrl_word[OS-1:0]),
        .bit_out   (hi_bit)
    );

    vcap_voter #(.OS(OS)) u_vote_lo (
        .win       (lo_window),
        .level_sel (ctrl_word[OS-1:0]),
        .bit_out   (lo_bit)
    );

    vcap_line_fsm #(
        .OS     (OS),
        .PIX    (PIX),
        .ROWS   (ROWS),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_rise  (hs_rise),
        .vs_rise  (vs_rise),
        .pix_bits ({hi_bit, lo_bit}),
        .state_o  (fsm_state),
        .fb_we    (fb_we),
        .fb_addr  (fb_addr),
        .fb_data  (fb_data)
    );

endmodule

// File: rtl/vcap_checker.sv
module vcap_checker
    import vcap_pkg::*;
#(
    parameter int OS   = 4,
    parameter int PIX  = 512,
    parameter int ROWS = 256,
    parameter int AW   = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fb_we,
    input logic [AW-1:0] fb_addr,
    input logic          vs_rise,
    input cap_state_e    state,
    input logic [OS-1:0] hi_win,
    input logic          hi_bit,
    input logic [OS+1:0] ctrl
);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (int'(fb_addr) < PIX * ROWS));

    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |=> !fb_we);

    p_zero_vote_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_win == '0) |-> !hi_bit);

    p_full_vote_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&hi_win) |-> (hi_bit == ctrl[OS-1]));

    p_vsync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> !fb_we);

    p_frame_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME_END) |=> !fb_we);

endmodule

bind vcap_pixel_capture vcap_checker #(
    .OS   (OS),
    .PIX  (PIX),
    .ROWS (ROWS),
    .AW   (ADDR_W)
) u_vcap_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_we   (fb_we),
    .fb_addr (fb_addr),
    .vs_rise (vs_rise),
    .state   (fsm_state),
    .hi_win  (hi_window),
    .hi_bit  (hi_bit),
    .ctrl    (ctrl_word)
);

// File: tb/vcap_pixel_capture_bench.sv
module vcap_pixel_capture_bench;

    localparam int OS   = 4;
    localparam int PIX  = 6;
    localparam int ROWS = 3;
    localparam int AW   = $clog2(PIX * ROWS);
    localparam int FULL_LINE = PIX * OS + 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync_in = 1'b0;
    logic          vsync_in = 1'b0;
    logic          vid_hi = 1'b0;
    logic          vid_lo = 1'b0;
    logic [5:0]    ctrl_word = 6'b111100;
    logic [AW-1:0] fb_addr;
    logic [1:0]    fb_data;
    logic          fb_we;

    vcap_pixel_capture #(.OS(OS), .PIX(PIX), .ROWS(ROWS)) u_vcap_pixel_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .vid_hi    (vid_hi),
        .vid_lo    (vid_lo),
        .ctrl_word (ctrl_word),
        .fb_addr   (fb_addr),
        .fb_data   (fb_data),
        .fb_we     (fb_we)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_h1, m_h2, m_h3, m_v1, m_v2, m_v3;
    int       m_st, m_row, m_col, m_ph;
    logic [3:0] rq_hi, rq_lo, fq_hi, fq_lo;
    int       exp_we, exp_addr, exp_data;

    function automatic int vote(input logic [3:0] w, input logic [5:0] c);
        int n;
        n = $countones(w);
        if (n == 0) return 0;
        return int'(c[n-1]);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_h1 = 0; m_h2 = 0; m_h3 = 0; m_v1 = 0; m_v2 = 0; m_v3 = 0;
            m_st = 0; m_row = 0; m_col = 0; m_ph = 0;
            rq_hi = '0; rq_lo = '0;
            exp_we = 0; exp_addr = 0; exp_data = 0;
        end else begin
            int hr, vr, lp, lc, lr;
            logic [3:0] wh, wl;
            hr = (m_h2 == 1 && m_h3 == 0) ? 1 : 0;
            vr = (m_v2 == 1 && m_v3 == 0) ? 1 : 0;
            lp = (m_ph == OS - 1) ? 1 : 0;
            lc = (m_col == PIX - 1) ? 1 : 0;
            lr = (m_row == ROWS - 1) ? 1 : 0;
            wh = ctrl_word[5] ? rq_hi : fq_hi;
            wl = ctrl_word[4] ? rq_lo : fq_lo;
            exp_we = (m_st == 1 && lp == 1 && vr == 0 && hr == 0) ? 1 : 0;
            if (exp_we == 1) begin
                exp_data = vote(wh, ctrl_word) * 2 + vote(wl, ctrl_word);
                exp_addr = m_row * PIX + m_col;
            end
            if (vr == 1) begin
                m_st = 0; m_row = 0; m_col = 0; m_ph = 0;
            end else if (hr == 1) begin
                if (m_st != 3) begin
                    m_ph = 0; m_col = 0;
                    if (m_st == 0) m_st = 1;
                    else if (lr == 1) m_st = 3;
                    else begin m_row++; m_st = 1; end
                end
            end else if (m_st == 1) begin
                if (lp == 1) begin
                    m_ph = 0;
                    if (lc == 1) m_st = 2; else m_col++;
                end else begin
                    m_ph++;
                end
            end
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = int'(hsync_in);
            m_v3 = m_v2; m_v2 = m_v1; m_v1 = int'(vsync_in);
            rq_hi = {rq_hi[2:0], vid_hi};
            rq_lo = {rq_lo[2:0], vid_lo};
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            fq_hi = '0; fq_lo = '0;
        end else begin
            fq_hi = {fq_hi[2:0], vid_hi};
            fq_lo = {fq_lo[2:0], vid_lo};
        end
    end

    // ---------------- per-cycle comparison and write tracking ----------------
    int wr_cnt, first_cyc, first_addr, last_addr, prev_cyc, hs_cyc;
    logic [1:0] or_data, and_data;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(fb_we) == exp_we, {cur_req, " strobe (R2)"}, int'(fb_we), exp_we);
            chk(int'(fb_addr) == exp_addr, {cur_req, " addr (R6)"}, int'(fb_addr), exp_addr);
            chk(int'(fb_data) == exp_data, {cur_req, " data (R4)"}, int'(fb_data), exp_data);
            if (fb_we) begin
                wr_cnt++;
                if (wr_cnt == 1) begin
                    first_cyc  = cyc;
                    first_addr = int'(fb_addr);
                end else begin
                    chk(cyc - prev_cyc == OS, "R2 spacing", cyc - prev_cyc, OS);
                end
                prev_cyc  = cyc;
                last_addr = int'(fb_addr);
                or_data   = or_data | fb_data;
                and_data  = and_data & fb_data;
            end
        end
    end

    // ---------------- stimulus ----------------
    int lfsr = 32'h1ace;

    task automatic set_video(input int kind, input int i);
        unique case (kind)
            0: begin vid_hi = 1'b0; vid_lo = 1'b0; end
            1: begin vid_hi = 1'b1; vid_lo = 1'b1; end
            2: begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
                vid_hi = lfsr[3];
                vid_lo = lfsr[7];
            end
            default: begin
                vid_hi = (i % 6) < 2;
                vid_lo = (i % 5) >= 3;
            end
        endcase
    endtask

    task automatic run_line(input int kind, input int ncyc);
        wr_cnt = 0;
        or_data = 2'b00;
        and_data = 2'b11;
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            #3;
            if (i == 0) hs_cyc = cyc;
            hsync_in = (i < 2);
            set_video(kind, i);
        end
    endtask

    task automatic vsync_pulse();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #3;
            vsync_in = (i < 2);
            vid_hi = 1'b0;
            vid_lo = 1'b0;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(fb_we == 1'b0, "R1 we", int'(fb_we), 0);
        chk(fb_addr == '0, "R1 addr", int'(fb_addr), 0);
        chk(fb_data == 2'b00, "R1 data", int'(fb_data), 0);
        @(posedge clk);
        #3;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(fb_we == 1'b0, "R1 we after release", int'(fb_we), 0);
        chk(fb_addr == '0, "R1 addr after release", int'(fb_addr), 0);

        // R10 / R7 / R6: first line of the frame, preferred control word
        cur_req = "R10";
        ctrl_word = 6'b111100;
        vsync_pulse();
        run_line(2, FULL_LINE);
        chk(first_cyc - hs_cyc == 7, "R10 first write latency", first_cyc - hs_cyc, 7);
        chk(wr_cnt == PIX, "R7 writes per line", wr_cnt, PIX);
        chk(first_addr == 0, "R6 row0 first addr", first_addr, 0);
        chk(last_addr == PIX - 1, "R6 row0 last addr", last_addr, PIX - 1);

        // R4: all ones, four-count level is 0
        cur_req = "R4";
        ctrl_word = 6'b110111;
        run_line(1, FULL_LINE);
        chk(or_data == 2'b00, "R4 four ones with level 0", int'(or_data), 0);
        chk(first_addr == PIX, "R6 row1 first addr", first_addr, PIX);

        // R3: all zeros with every level on
        cur_req = "R3";
        ctrl_word = 6'b111111;
        run_line(0, FULL_LINE);
        chk(wr_cnt == PIX, "R3 line writes", wr_cnt, PIX);
        chk(or_data == 2'b00, "R3 zero samples give 0", int'(or_data), 0);
        chk(last_addr == 3 * PIX - 1, "R6 row2 last addr", last_addr, 3 * PIX - 1);

        // R9: hsync while last row is current
        cur_req = "R9";
        run_line(2, FULL_LINE);
        chk(wr_cnt == 0, "R9 writes after frame full", wr_cnt, 0);

        // R8: vsync restarts the frame; falling edges for both bits
        cur_req = "R8";
        ctrl_word = 6'b001111;
        vsync_pulse();
        run_line(1, FULL_LINE);
        chk(first_addr == 0, "R8 first addr after vsync", first_addr, 0);
        chk(and_data == 2'b11, "R4 four ones with level 1", int'(and_data), 3);

        // R5: mixed edges on a striped pattern
        cur_req = "R5";
        ctrl_word = 6'b100110;
        run_line(3, FULL_LINE);
        ctrl_word = 6'b011010;
        vsync_pulse();
        run_line(3, FULL_LINE);
        run_line(2, FULL_LINE);

        // R7: early hsync cuts a line short
        cur_req = "R7";
        ctrl_word = 6'b111100;
        run_line(2, 14);
        chk(wr_cnt < PIX, "R7 short line writes", wr_cnt, 2);
        vsync_pulse();
        cur_req = "R6";
        run_line(2, FULL_LINE);
        run_line(3, FULL_LINE + 12);
        chk(wr_cnt == PIX, "R7 long line writes", wr_cnt, PIX);
        chk(last_addr == 2 * PIX - 1, "R6 row1 last addr", last_addr, 2 * PIX - 1);

        repeat (4) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule